// File: doc/BRIEF.md
# Conditionally Stalled Read-Modify-Write Pipeline

This block is a streaming update engine. Each item on its input stream names a word of an on-chip state memory and carries an operand. The engine reads that word, adds the operand to it with wrap-around, and writes the sum back to the same word. Read and write-back are separated by a fixed number of pipeline cycles, so one item can depend on another that is still in flight. A histogram or a per-key accumulator is the typical use.

Only the input is held back, and only when an address really collides. A small set of comparators checks the address at the head of the stream against every item whose write-back has not yet landed. With no match, one item enters per cycle at any pipeline depth. With a match, the input waits, and the items already inside keep moving until the colliding write-back has been stored. Nothing is forwarded between stages: a collision is resolved only by waiting. A host port loads the memory before a run and reads it back afterwards. A flag reports when the pipeline holds no work.

Top module: `rmw_stall_engine`

## Requirements
- R1: When the head item's address matches no in-flight item, and the host port is idle, `in_ready` is high. A stream of mutually non-conflicting items is accepted on consecutive cycles (one item per cycle), whatever the value of `LAT`.
- R2: `in_ready` is low in every cycle where `in_addr` equals the address of an item accepted 1 to `LAT`-1 cycles earlier. An item accepted `LAT` or more cycles earlier never blocks.
- R3: A blocked item is accepted in the cycle exactly `LAT` cycles after the most recent accepted item with the same address, unless an earlier bound applies. A stream that repeats one address is therefore accepted once every `LAT` cycles.
- R4: Each accepted item replaces the word at its address with the old word plus its operand, modulo 2^`DATA_W`. After a run, the memory equals the result of applying all updates one by one in acceptance order.
- R5: `drained` is high exactly when no accepted item still has its write-back outstanding. For a last item accepted in cycle t, `drained` is low in cycles t+1 to t+`LAT`-1 and high from cycle t+`LAT`.
- R6: The host port writes `host_wdata` to word `host_addr` in a cycle with `host_wr` high. With `host_rd` high, `host_rdata` holds that word in the next cycle. The stream input is not ready during a host access.
- R7: A stall holds only the input stage. Every item already accepted performs its write-back `LAT`-1 cycles after its acceptance, so the pipeline drains on schedule while the input waits.
- R8: After reset, `in_ready` and `drained` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Head item of the update stream is valid |
| in_ready | output | 1 | Engine accepts the head item this cycle |
| in_addr | input | ADDR_W | Word address of the head item |
| in_operand | input | DATA_W | Value to add to the addressed word |
| host_wr | input | 1 | Host writes a memory word |
| host_rd | input | 1 | Host reads a memory word |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, one cycle after host_rd |
| drained | output | 1 | No update is in flight |

## Verification
The bench targets the collision distances around the pipeline depth. It sends the same address with 1, 2 and 3 other items in between, and also with `LAT`-1 items in between. A hazard window one stage too short would accept the repeat too early, lose an update and corrupt the final word. A window one stage too long would stall on the last pattern, and the measured acceptance cycle would drift. Back-to-back repeats of one address check that the input resumes exactly `LAT` cycles apart and no later. Long distinct-address streams show whether a bubble left in a stage still counts as a match, which would add stalls. Start values near 2^32 catch an addition that saturates instead of wrapping. The drain timing after a stalled stream shows whether the later stages were wrongly frozen along with the input.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  // Which agent owns the memory write port in a given cycle.
  typedef enum logic [1:0] {
    WSRC_NONE = 2'd0,
    WSRC_PIPE = 2'd1,
    WSRC_HOST = 2'd2
  } wsrc_e;

endpackage

// File: rtl/rmw_state_mem.sv
module rmw_state_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  // A read returns data one cycle after the address.
  // A write lands at the clock edge and is seen by reads issued in the next cycle.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rmw_hazard_unit.sv
module rmw_hazard_unit #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic [ADDR_W-1:0]             probe_addr,
  input  logic [DEPTH-1:0]              stage_vld,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  stage_addr,
  output logic                          hit
);
  logic [DEPTH-1:0] match;

  // One comparator per in-flight stage. A bubble never matches.
  for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
    assign match[j] = stage_vld[j] && (stage_addr[j] == probe_addr);
  end

  assign hit = |match;

endmodule

// File: rtl/rmw_stage_pipe.sv
module rmw_stage_pipe #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LAT    = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              accept,
  input  logic [ADDR_W-1:0]                 acc_addr,
  input  logic [DATA_W-1:0]                 acc_op,
  input  logic [DATA_W-1:0]                 rd_data,
  output logic [LAT-2:0]                    stage_vld,
  output logic [LAT-2:0][ADDR_W-1:0]        stage_addr,
  output logic                              wr_en,
  output logic [ADDR_W-1:0]                 wr_addr,
  output logic [DATA_W-1:0]                 wr_data
);
  localparam int NST = LAT - 1;   // registered stages between read issue and write-back

  logic [NST-1:0]             vld_q, vld_d;
  logic [NST-1:0]             en;
  logic [NST-1:0][ADDR_W-1:0] addr_q, addr_d;
  logic [NST-1:0][DATA_W-1:0] dat_q, dat_d;
  logic [NST-1:0][DATA_W-1:0] val;

  // Stage 0 holds the operand while the read is under way.
  // The sum is formed there, and later stages only carry it along.
  always_comb begin
    val    = dat_q;
    val[0] = rd_data + dat_q[0];
    vld_d  = NST'({vld_q, accept});
    en     = NST'({vld_q, accept});
    addr_d = (NST*ADDR_W)'({addr_q, acc_addr});
    dat_d  = (NST*DATA_W)'({val, acc_op});
  end

  // Every stage advances every cycle. A stall only keeps new items out.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < NST; j++) begin
      if (en[j]) begin
        addr_q[j] <= addr_d[j];
        dat_q[j]  <= dat_d[j];
      end
    end
  end

  assign stage_vld  = vld_q;
  assign stage_addr = addr_q;
  assign wr_en      = vld_q[NST-1];
  assign wr_addr    = addr_q[NST-1];
  assign wr_data    = val[NST-1];

endmodule

// File: rtl/rmw_stall_engine.sv
module rmw_stall_engine #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_operand,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              drained
);
  import rmw_pkg::*;

  localparam int NST = LAT - 1;

  // Reset is asserted asynchronously and released in step with the clock.
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic [NST-1:0]             stage_vld;
  logic [NST-1:0][ADDR_W-1:0] stage_addr;
  logic                       hit;
  logic                       accept;
  logic                       pipe_we;
  logic [ADDR_W-1:0]          pipe_waddr;
  logic [DATA_W-1:0]          pipe_wdata;
  logic [DATA_W-1:0]          rd_data;
  logic [ADDR_W-1:0]          mem_raddr;
  logic [ADDR_W-1:0]          mem_waddr;
  logic [DATA_W-1:0]          mem_wdata;
  wsrc_e                      wsrc;

  rmw_hazard_unit #(.ADDR_W(ADDR_W), .DEPTH(NST)) u_hazard (
    .probe_addr (in_addr),
    .stage_vld  (stage_vld),
    .stage_addr (stage_addr),
    .hit        (hit)
  );

  // The host has priority. The stream waits on a collision or during host access.
  assign in_ready = !hit && !host_wr && !host_rd;
  assign accept   = in_valid && in_ready;

  rmw_stage_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_q),
    .accept     (accept),
    .acc_addr   (in_addr),
    .acc_op     (in_operand),
    .rd_data    (rd_data),
    .stage_vld  (stage_vld),
    .stage_addr (stage_addr),
    .wr_en      (pipe_we),
    .wr_addr    (pipe_waddr),
    .wr_data    (pipe_wdata)
  );

  always_comb begin
    if (pipe_we)      wsrc = WSRC_PIPE;
    else if (host_wr) wsrc = WSRC_HOST;
    else              wsrc = WSRC_NONE;
    mem_waddr = (wsrc == WSRC_HOST) ? host_addr  : pipe_waddr;
    mem_wdata = (wsrc == WSRC_HOST) ? host_wdata : pipe_wdata;
    mem_raddr = host_rd ? host_addr : in_addr;
  end

  rmw_state_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (wsrc != WSRC_NONE),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (rd_data)
  );

  assign host_rdata = rd_data;
  assign drained    = ~|stage_vld;

endmodule

// File: rtl/rmw_stall_checker.sv
module rmw_stall_checker #(
  parameter int ADDR_W = 8,
  parameter int LAT    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic              pipe_we,
  input logic [ADDR_W-1:0] pipe_waddr,
  input logic              drained
);
  localparam int NST = LAT - 1;

  // The checker keeps its own record of recent acceptances, built from the ports.
  logic [NST-1:0]             hv;
  logic [NST-1:0][ADDR_W-1:0] ha;
  logic                       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv <= '0;
      ha <= '0;
    end else begin
      hv <= NST'({hv, in_valid && in_ready});
      ha <= (NST*ADDR_W)'({ha, in_addr});
    end
  end

  always_comb begin
    seen = 1'b0;
    for (int j = 0; j < NST; j++) seen = seen | (hv[j] && ha[j] == in_addr);
  end

  p_free_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !seen && !host_wr && !host_rd |-> in_ready);

  p_hold_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> !in_ready);

  p_repeat_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready) && in_addr == $past(in_addr) |-> !in_ready);

  p_write_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hv[NST-1] |-> pipe_we && pipe_waddr == ha[NST-1]);

  p_no_stray_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hv[NST-1] |-> !pipe_we);

  p_drained_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drained == !(|hv));

  p_host_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr || host_rd) |-> !in_ready);

endmodule

bind rmw_stall_engine rmw_stall_checker #(.ADDR_W(ADDR_W), .LAT(LAT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_addr    (in_addr),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .pipe_we    (pipe_we),
  .pipe_waddr (pipe_waddr),
  .drained    (drained)
);

// File: tb/rmw_stall_engine_bench.sv
module rmw_stall_engine_bench;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int LAT    = 4;
  localparam int WORDS  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [ADDR_W-1:0] in_addr;
  logic [DATA_W-1:0] in_operand;
  logic              host_wr;
  logic              host_rd;
  logic [ADDR_W-1:0] host_addr;
  logic [DATA_W-1:0] host_wdata;
  logic [DATA_W-1:0] host_rdata;
  logic              drained;

  rmw_stall_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)) u_rmw_stall_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_operand(in_operand), .host_wr(host_wr),
    .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .drained(drained)
  );

  always #4 clk = ~clk;   // 125 MHz

  int                n_chk = 0;
  int                n_fail = 0;
  int                cyc = 0;
  logic              rd_d = 1'b0;
  logic [DATA_W-1:0] ref_mem [WORDS];
  int                last_acc [WORDS];
  int                last_any = 0;
  logic [DATA_W-1:0] exp_q [$];
  string             cur_req = "R6";
  logic [31:0]       seed = 32'h1234_5678;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    rd_d <= host_rd;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // Monitor: pops the expected word for each host read once the data appears.
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) check(1'b0, cur_req, "unexpected read data", 0, 1);
      else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        check(host_rdata == e, cur_req, "memory word", host_rdata, e);
      end
    end
  end

  // Driver: offers one item and waits until it is accepted. The acceptance
  // cycle is predicted from the address history kept for R1/R3.
  task automatic send(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] op);
    int offer;
    int expc;
    int got;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_operand = op;
    offer = cyc;
    expc  = (last_acc[a] + LAT > offer) ? last_acc[a] + LAT : offer;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
      if (cyc > offer + 4 * LAT) break;
    end
    got = cyc;
    if (expc == offer) check(got == expc, "R1", "accept cycle, no conflict", got, expc);
    else               check(got == expc, "R3", "accept cycle after stall", got, expc);
    @(posedge clk);
    last_acc[a] = got;
    last_any    = got;
    ref_mem[a]  = ref_mem[a] + op;
  endtask

  task automatic drain_check(input string req);
    @(negedge clk);
    in_valid = 1'b0;
    while (cyc < last_any + LAT - 1) @(negedge clk);
    #1 check(drained == 1'b0, req, "drained during last write-back", drained, 0);
    @(negedge clk);
    #1 check(drained == 1'b1, req, "drained after last write-back", drained, 1);
  endtask

  task automatic read_all(input string req);
    cur_req = req;
    for (int a = 0; a < WORDS; a++) begin
      @(negedge clk);
      host_rd = 1'b1; host_addr = ADDR_W'(a);
      exp_q.push_back(ref_mem[a]);
    end
    @(negedge clk);
    host_rd = 1'b0;
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, req, "pending reads", exp_q.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_operand = '0;
    host_wr = 1'b0; host_rd = 1'b0; host_addr = '0; host_wdata = '0;
    for (int a = 0; a < WORDS; a++) last_acc[a] = -1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
    check(drained == 1'b1, "R8", "drained after reset", drained, 1);

    // Load start values; odd words sit near the top of the range to force wrap-around.
    for (int a = 0; a < WORDS; a++) begin
      @(negedge clk);
      host_wr = 1'b1; host_addr = ADDR_W'(a);
      host_wdata = a[0] ? (32'hFFFF_FF00 | 32'(a)) : 32'(a) * 32'h0100_0193;
      ref_mem[a] = host_wdata;
    end
    @(negedge clk);
    host_wr = 1'b0;
    read_all("R6");

    // Distinct addresses: one item per cycle.
    for (int i = 0; i < 40; i++) send(ADDR_W'(i * 7), 32'(i) * 32'h0101_0101 + 32'h200);
    drain_check("R5");

    // One address repeated back to back.
    for (int i = 0; i < 16; i++) send(8'h42, 32'(i + 1) * 32'h1000_0001);
    drain_check("R7");

    // Same address at distances 2, 3, 4 and LAT.
    send(8'd10, 32'd1); send(8'd11, 32'd2); send(8'd10, 32'd3);
    send(8'd20, 32'd4); send(8'd21, 32'd5); send(8'd22, 32'd6); send(8'd20, 32'd7);
    send(8'd30, 32'd8); send(8'd31, 32'd9); send(8'd32, 32'd10); send(8'd33, 32'd11);
    send(8'd30, 32'd12);
    drain_check("R7");

    // Skewed: mostly four hot words.
    for (int i = 0; i < 200; i++) begin
      logic [31:0] r;
      r = rnd();
      send((r[3:0] == 4'd0) ? r[15:8] : {6'd0, r[5:4]}, rnd());
    end
    drain_check("R7");

    // Uniform random.
    for (int i = 0; i < 200; i++) begin
      logic [31:0] r;
      r = rnd();
      send(r[19:12], rnd());
    end
    drain_check("R5");

    read_all("R4");
    report();
  end

endmodule